// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 24-bit virtual address into a memory address. A 512-entry table holds one frame descriptor for each page. A descriptor gives the frame number, a valid flag and a page-size flag that picks 2 KB or 4 KB pages. The address is split into four fields. A privileged requester can ask for a direct, untranslated access with a flag bit. Plain non-translating operation and I/O traffic pass through without any change.

Each request is taken on one clock edge, and the result comes back one cycle later with a strobe. Along with the address, the result carries one of two error flags. The segment error means that reserved segment bits were set. The paging error means a missing entry, or a displacement that falls outside a 2 KB page. The processor loads the table through a single write port.

Top module: `vaddr_xlate`

## Requirements
- R1: The virtual address is split as follows. Bit 23 is the direct flag. Bits 22:18 are the segment, bits 17:12 are the page and bits 11:0 are the displacement.
- R2: When `req_xlate` is 0, the result address equals the request address and no error flag is raised.
- R3: When `req_io` is 1, the address passes unchanged and raises no error, even when translation is enabled.
- R4: A direct access needs all of the following: translation on, not I/O, bit 23 set, `req_priv` = 1 and `req_base` = 1. It returns `{1'b0, vaddr[22:0]}` and raises no error. With bit 23 set but `req_priv` = 0, the address is translated normally.
- R5: When `req_base` = 0, the direct flag counts as 0 and the segment counts as 0. No segment error is possible in this case, and the table index is `{3'b000, page}`.
- R6: If segment bits 4:3 are not both zero on a translated access, `rsp_seg_err` is 1 and `rsp_addr` is 0.
- R7: The table index is `{segment[2:0], page}`, which is 9 bits wide.
- R8: An entry with the small-page flag clear gives a 4 KB page. The result is `{frame[7:0], disp[11:0]}`, zero-extended to 24 bits.
- R9: An entry with the small-page flag set gives a 2 KB page. The result is `{frame[8:0], disp[10:0]}`. If `disp[11]` = 1, the block raises `rsp_page_err` and the address is 0.
- R10: Using an entry whose valid flag is 0 raises `rsp_page_err`, and the address is 0. After reset, every entry is invalid.
- R11: `rsp_valid` goes high exactly one cycle after `req_valid` and is low otherwise. If a table write hits the looked-up entry in the same cycle, the lookup returns the old contents.
- R12: The two error flags are never high together, and neither is high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 24 | Virtual address |
| req_xlate | input | 1 | 1 = translating mode, 0 = pass-through |
| req_priv | input | 1 | Requester is privileged |
| req_base | input | 1 | A base register supplied the segment |
| req_io | input | 1 | I/O access, never translated |
| wr_en | input | 1 | Table write strobe |
| wr_index | input | 9 | Entry written |
| wr_valid | input | 1 | Valid flag written |
| wr_small | input | 1 | Small-page (2 KB) flag written |
| wr_frame | input | 9 | Frame number written |
| rsp_valid | output | 1 | Result strobe |
| rsp_addr | output | 24 | Resulting memory address |
| rsp_seg_err | output | 1 | Reserved segment bits set |
| rsp_page_err | output | 1 | Invalid entry or 2 KB overflow |

## Verification
The bound checker watches the following on every cycle: the request-to-result latency, the pass-through and I/O paths, direct access, and the segment-error rule. These depend only on the request pins. It also checks that the two error flags exclude each other. Everything that depends on table contents can only be shown by the bench's scenarios. That covers frame joining for both page sizes, the 2 KB overflow, invalid entries, index formation without a base register, and the old-data result when a write hits the entry being read.

// File: rtl/vxl_pkg.sv
`timescale 1ns/1ps
package vxl_pkg;
  localparam int VA_W     = 24;
  localparam int DISP_W   = 12;
  localparam int PAGE_W   = 6;
  localparam int SEG_W    = 5;
  localparam int SEG_USED = 3;
  localparam int IDX_W    = SEG_USED + PAGE_W;

  typedef struct packed {
    logic              dbit;
    logic [SEG_W-1:0]  seg;
    logic [PAGE_W-1:0] page;
    logic [DISP_W-1:0] disp;
  } vfields_t;

  typedef enum logic [1:0] {
    RT_PASS   = 2'd0,
    RT_DIRECT = 2'd1,
    RT_LOOKUP = 2'd2,
    RT_SEGERR = 2'd3
  } route_t;
endpackage

// File: rtl/vxl_decode.sv
`timescale 1ns/1ps
module vxl_decode
  import vxl_pkg::*;
(
  input  logic [VA_W-1:0]   vaddr,
  input  logic              xlate,
  input  logic              priv,
  input  logic              base,
  input  logic              io,
  output route_t            route,
  output logic [IDX_W-1:0]  idx,
  output logic [DISP_W-1:0] disp
);
  vfields_t         f;
  logic [SEG_W-1:0] seg_eff;
  logic             d_eff;

  always_comb begin
    f       = vfields_t'(vaddr);
    seg_eff = base ? f.seg : '0;
    d_eff   = base & f.dbit;
    if (!xlate || io)                        route = RT_PASS;
    else if (d_eff && priv)                  route = RT_DIRECT;
    else if (|seg_eff[SEG_W-1:SEG_USED])     route = RT_SEGERR;
    else                                     route = RT_LOOKUP;
    idx  = {seg_eff[SEG_USED-1:0], f.page};
    disp = f.disp;
  end
endmodule

// File: rtl/vxl_table.sv
`timescale 1ns/1ps
module vxl_table #(
  parameter int IDX_W   = 9,
  parameter int FRAME_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_small,
  input  logic [FRAME_W:0] wr_frame,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_small,
  output logic [FRAME_W:0] rd_frame
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic [DEPTH-1:0] small_q;
  logic [FRAME_W:0] frame_q [DEPTH];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = wr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      small_q[wr_idx] <= wr_small;
      frame_q[wr_idx] <= wr_frame;
    end
  end

  // Combinational read of current contents: a write in the same cycle
  // lands only at the edge, so the lookup sees the old entry.
  assign rd_valid = valid_q[rd_idx];
  assign rd_small = small_q[rd_idx];
  assign rd_frame = frame_q[rd_idx];
endmodule

// File: rtl/vxl_compose.sv
`timescale 1ns/1ps
module vxl_compose
  import vxl_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  route_t            route,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [DISP_W-1:0] disp,
  input  logic              ent_valid,
  input  logic              ent_small,
  input  logic [FRAME_W:0]  ent_frame,
  output logic [VA_W-1:0]   addr,
  output logic              seg_err,
  output logic              page_err
);
  localparam int PA_W = FRAME_W + DISP_W;

  logic [PA_W-1:0] pa_big, pa_small;

  assign pa_big   = {ent_frame[FRAME_W-1:0], disp};
  assign pa_small = {ent_frame, disp[DISP_W-2:0]};

  always_comb begin
    addr     = '0;
    seg_err  = 1'b0;
    page_err = 1'b0;
    case (route)
      RT_PASS:   addr = vaddr;
      RT_DIRECT: addr = {1'b0, vaddr[VA_W-2:0]};
      RT_SEGERR: seg_err = 1'b1;
      default: begin
        if (!ent_valid)                      page_err = 1'b1;
        else if (ent_small && disp[DISP_W-1]) page_err = 1'b1;
        else if (ent_small)                  addr = VA_W'(pa_small);
        else                                 addr = VA_W'(pa_big);
      end
    endcase
  end
endmodule

// File: rtl/vaddr_xlate.sv
`timescale 1ns/1ps
module vaddr_xlate
  import vxl_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_xlate,
  input  logic             req_priv,
  input  logic             req_base,
  input  logic             req_io,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  input  logic             wr_valid,
  input  logic             wr_small,
  input  logic [FRAME_W:0] wr_frame,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_addr,
  output logic             rsp_seg_err,
  output logic             rsp_page_err
);
  logic rst_meta_q, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  route_t            route;
  logic [IDX_W-1:0]  idx;
  logic [DISP_W-1:0] disp;
  logic              ent_valid, ent_small;
  logic [FRAME_W:0]  ent_frame;
  logic [VA_W-1:0]   addr_c;
  logic              seg_err_c, page_err_c;

  vxl_decode u_dec (
    .vaddr(req_vaddr), .xlate(req_xlate), .priv(req_priv), .base(req_base),
    .io(req_io), .route(route), .idx(idx), .disp(disp)
  );

  vxl_table #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_tbl (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_idx(wr_index),
    .wr_valid(wr_valid), .wr_small(wr_small), .wr_frame(wr_frame),
    .rd_idx(idx), .rd_valid(ent_valid), .rd_small(ent_small), .rd_frame(ent_frame)
  );

  vxl_compose #(.FRAME_W(FRAME_W)) u_cmp (
    .route(route), .vaddr(req_vaddr), .disp(disp), .ent_valid(ent_valid),
    .ent_small(ent_small), .ent_frame(ent_frame), .addr(addr_c),
    .seg_err(seg_err_c), .page_err(page_err_c)
  );

  logic            vld_d, serr_d, perr_d;
  logic [VA_W-1:0] addr_d;

  always_comb begin
    vld_d  = req_valid;
    serr_d = req_valid & seg_err_c;
    perr_d = req_valid & page_err_c;
    addr_d = req_valid ? addr_c : rsp_addr;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid    <= 1'b0;
      rsp_seg_err  <= 1'b0;
      rsp_page_err <= 1'b0;
      rsp_addr     <= '0;
    end else begin
      rsp_valid    <= vld_d;
      rsp_seg_err  <= serr_d;
      rsp_page_err <= perr_d;
      rsp_addr     <= addr_d;
    end
  end
endmodule

// File: rtl/vxl_chk.sv
`timescale 1ns/1ps
module vxl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [23:0] req_vaddr,
  input logic        req_xlate,
  input logic        req_priv,
  input logic        req_base,
  input logic        req_io,
  input logic        rsp_valid,
  input logic [23:0] rsp_addr,
  input logic        rsp_seg_err,
  input logic        rsp_page_err
);
  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_pass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_xlate) |=>
      (rsp_addr == $past(req_vaddr) && !rsp_seg_err && !rsp_page_err));

  a_r3_io_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_io) |=>
      (rsp_addr == $past(req_vaddr) && !rsp_seg_err && !rsp_page_err));

  a_r4_direct_access: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xlate && !req_io && req_priv && req_base && req_vaddr[23]) |=>
      (rsp_addr == {1'b0, $past(req_vaddr[22:0])} && !rsp_seg_err && !rsp_page_err));

  a_r6_seg_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_xlate && !req_io && req_base && (|req_vaddr[22:21]) &&
     !(req_priv && req_vaddr[23])) |=> (rsp_seg_err && rsp_addr == 24'd0));

  a_r5_nobase_no_segerr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_base) |=> !rsp_seg_err);

  a_r12_errors_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_seg_err && rsp_page_err));

  a_r12_error_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_seg_err || rsp_page_err) |-> rsp_valid);
endmodule

bind vaddr_xlate vxl_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_xlate(req_xlate), .req_priv(req_priv), .req_base(req_base), .req_io(req_io),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_seg_err(rsp_seg_err),
  .rsp_page_err(rsp_page_err)
);

// File: tb/tb_vaddr_xlate.sv
`timescale 1ns/1ps
module tb_vaddr_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_xlate, req_priv, req_base, req_io;
  logic [23:0] req_vaddr;
  logic        wr_en, wr_valid, wr_small;
  logic [8:0]  wr_index, wr_frame;
  logic        rsp_valid, rsp_seg_err, rsp_page_err;
  logic [23:0] rsp_addr;

  always #2.5 clk = ~clk;

  vaddr_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_xlate(req_xlate), .req_priv(req_priv), .req_base(req_base), .req_io(req_io),
    .wr_en(wr_en), .wr_index(wr_index), .wr_valid(wr_valid), .wr_small(wr_small),
    .wr_frame(wr_frame), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_seg_err(rsp_seg_err), .rsp_page_err(rsp_page_err)
  );

  typedef struct {
    logic [23:0] addr;
    logic        se;
    logic        pe;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0;
  int     errors = 0;
  bit     done   = 0;
  logic       m_valid [512];
  logic       m_small [512];
  logic [8:0] m_frame [512];

  task automatic model(input logic [23:0] va, input logic x, p, b, io,
                       output logic [23:0] a, output logic se, pe);
    logic [4:0] seg;
    logic [8:0] ix;
    a = 24'd0; se = 1'b0; pe = 1'b0;
    seg = b ? va[22:18] : 5'd0;
    ix  = {seg[2:0], va[17:12]};
    if (!x || io)                 a = va;
    else if (b && va[23] && p)    a = {1'b0, va[22:0]};
    else if (seg[4:3] != 2'b00)   se = 1'b1;
    else if (!m_valid[ix])        pe = 1'b1;
    else if (m_small[ix]) begin
      if (va[11]) pe = 1'b1;
      else        a = 24'({m_frame[ix], va[10:0]});
    end else      a = 24'({m_frame[ix][7:0], va[11:0]});
  endtask

  task automatic push_exp(input logic [23:0] va, input logic x, p, b, io, input string tag);
    exp_t e;
    model(va, x, p, b, io, e.addr, e.se, e.pe);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic quiet();
    req_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic req(input logic [23:0] va, input logic x, p, b, io, input string tag);
    @(negedge clk);
    quiet();
    push_exp(va, x, p, b, io, tag);
    req_valid = 1'b1; req_vaddr = va; req_xlate = x;
    req_priv = p; req_base = b; req_io = io;
  endtask

  task automatic wr(input logic [8:0] ix, input logic v, s, input logic [8:0] fr);
    @(negedge clk);
    quiet();
    wr_en = 1'b1; wr_index = ix; wr_valid = v; wr_small = s; wr_frame = fr;
    m_valid[ix] = v; m_small[ix] = s; m_frame[ix] = fr;
  endtask

  task automatic req_wr(input logic [23:0] va, input logic [8:0] ix, input logic [8:0] fr,
                        input string tag);
    @(negedge clk);
    push_exp(va, 1'b1, 1'b0, 1'b1, 1'b0, tag);   // expectation from old contents
    req_valid = 1'b1; req_vaddr = va; req_xlate = 1'b1;
    req_priv = 1'b0; req_base = 1'b1; req_io = 1'b0;
    wr_en = 1'b1; wr_index = ix; wr_valid = 1'b1; wr_small = 1'b0; wr_frame = fr;
    m_valid[ix] = 1'b1; m_small[ix] = 1'b0; m_frame[ix] = fr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      quiet();
    end
  endtask

  // Monitor: samples 1 ns after each rising edge and scores against the queue.
  always @(posedge clk) begin
    #1;
    if (rst_n && rsp_valid && !done) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected rsp_valid: actual addr=%h expected no response", rsp_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_addr !== e.addr || rsp_seg_err !== e.se || rsp_page_err !== e.pe) begin
          errors++;
          $display("FAIL %s actual addr=%h se=%b pe=%b expected addr=%h se=%b pe=%b",
                   e.tag, rsp_addr, rsp_seg_err, rsp_page_err, e.addr, e.se, e.pe);
        end
      end
    end
  end

  function automatic logic [23:0] va_of(input logic d, input logic [4:0] s,
                                        input logic [5:0] pg, input logic [11:0] ds);
    return {d, s, pg, ds};
  endfunction

  initial begin
    for (int i = 0; i < 512; i++) begin
      m_valid[i] = 1'b0; m_small[i] = 1'b0; m_frame[i] = 9'd0;
    end
    rst_n = 1'b0;
    req_valid = 0; req_vaddr = 0; req_xlate = 0; req_priv = 0; req_base = 0; req_io = 0;
    wr_en = 0; wr_index = 0; wr_valid = 0; wr_small = 0; wr_frame = 0;
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // Reset state (R11)
    checks++;
    if (rsp_valid !== 1'b0 || rsp_seg_err !== 1'b0 || rsp_page_err !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state actual v=%b se=%b pe=%b expected 0 0 0",
               rsp_valid, rsp_seg_err, rsp_page_err);
    end

    // R10: all entries invalid after reset
    req(va_of(0, 5'd1, 6'd9, 12'h010), 1, 0, 1, 0, "R10 invalid after reset");
    // R2: pass-through, several patterns
    req(24'hFFFFFF, 0, 1, 1, 0, "R2 pass all ones");
    req(24'h9A5C33, 0, 0, 0, 0, "R2 pass pattern");
    // R3: I/O never translated
    req(24'hE01234, 1, 1, 1, 1, "R3 io pass");
    req(24'h7F0ABC, 1, 0, 0, 1, "R3 io pass no base");

    // R1 R7 R8: 4 KB entry at {seg=2, page=5}
    wr({3'd2, 6'd5}, 1, 0, 9'h1AB);
    req(va_of(0, 5'd2, 6'd5, 12'h123), 1, 0, 1, 0, "R8 4KB join");
    req(va_of(0, 5'd2, 6'd5, 12'hFFF), 1, 0, 1, 0, "R1 field split");
    req(va_of(0, 5'd5, 6'd5, 12'h123), 1, 0, 1, 0, "R7 other segment index");

    // R9: 2 KB entry
    wr({3'd0, 6'd7}, 1, 1, 9'h155);
    req(va_of(0, 5'd0, 6'd7, 12'h3FF), 1, 0, 1, 0, "R9 2KB join");
    req(va_of(0, 5'd0, 6'd7, 12'h7FF), 1, 0, 1, 0, "R9 2KB top in range");
    req(va_of(0, 5'd0, 6'd7, 12'h800), 1, 0, 1, 0, "R9 2KB overflow");

    // R6: reserved segment bits
    req(va_of(0, 5'b01010, 6'd5, 12'h001), 1, 1, 1, 0, "R6 seg bit3");
    req(va_of(1, 5'b10000, 6'd5, 12'h001), 1, 0, 1, 0, "R6 seg bit4 unprivileged");

    // R5: no base register -> segment 0, direct flag ignored
    wr({3'd0, 6'd5}, 1, 0, 9'h0C3);
    req(va_of(1, 5'b11111, 6'd5, 12'h456), 1, 1, 0, 0, "R5 no base forces seg0");

    // R4: direct access
    req(va_of(1, 5'b11010, 6'd3, 12'hABC), 1, 1, 1, 0, "R4 direct privileged");
    req(va_of(1, 5'd2, 6'd5, 12'h042), 1, 0, 1, 0, "R4 direct bit unprivileged translates");

    // R11: same-cycle write returns old contents
    wr({3'd3, 6'd12}, 1, 0, 9'h011);
    req_wr(va_of(0, 5'd3, 6'd12, 12'h0F0), {3'd3, 6'd12}, 9'h022, "R11 same-cycle old data");
    req(va_of(0, 5'd3, 6'd12, 12'h0F0), 1, 0, 1, 0, "R11 new data after write");

    // R10: invalidation
    wr({3'd2, 6'd5}, 0, 0, 9'h1AB);
    req(va_of(0, 5'd2, 6'd5, 12'h123), 1, 0, 1, 0, "R10 invalidated entry");

    // R12 and R2: back-to-back mixed stream
    for (int i = 0; i < 16; i++) begin
      logic [23:0] va;
      va = 24'h135A00 ^ (24'h0B3D07 * i);
      req(va, i[0], i[1], i[2], i[3], "R12 mixed stream");
    end
    idle(4);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 missing responses actual=%0d expected 0", sb.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule